// File: doc/BRIEF.md
# Dual-Source Interrupt Status Latch

This block merges two interrupt sources into one active-low maskable interrupt request for the CPU. The first source is a slow periodic real-time tick that comes from another clock domain. The second source is a completion request from a disk controller, which is synchronous to the block clock. Each source has its own sticky pending flag. The interrupt line stays asserted for as long as either flag is set.

Software polls the block by reading one fixed memory-mapped status address. That read returns the pending flags on the two most significant data bits. It also acknowledges the tick source. The disk flag is left alone by that read. It is cleared by a separate strobe, which stands for the CPU reading the controller's own status register. When a new event arrives in the same cycle as its clear, the event wins. This way no interrupt is lost.

Top module: `irq_status_latch`

## Requirements
- R1: The tick input passes through a two-stage synchroniser and an edge detector. A rising edge that is first sampled at clock edge k sets the tick pending flag at edge k+2, so it is visible after edge k+2. Each rising edge sets the flag once only. A tick held high does not set the flag again after it has been cleared.
- R2: A disk request that is high at a clock edge sets the disk pending flag after that edge. The flag stays set after the request falls.
- R3: `irq_n` is 0 exactly when at least one pending flag is set, and 1 otherwise.
- R4: A status read is `rd_stb` = 1 with `addr` = 16'h37E0. During a status read, `stat_q` shows the tick flag on bit 7 and the disk flag on bit 6, with bits 5..0 at 0. These values appear in the same cycle, taken from the flags as they stand before that cycle's edge.
- R5: `stat_q` is 8'h00 whenever no status read is present. This covers `rd_stb` = 0, and also any other address with `rd_stb` = 1. Such accesses leave both flags unchanged.
- R6: A status read clears the tick flag at the next edge. It does not change the disk flag.
- R7: `dsk_clr` = 1 clears the disk flag at the next edge. It does not change the tick flag.
- R8: When a flag's set and its clear fall on the same edge, the set wins and the flag stays pending.
- R9: `rst_n` is a synchronous active-low reset. A reset edge clears both flags and the synchroniser, and leaves `irq_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_in | input | 1 | Periodic real-time tick, asynchronous to clk |
| dsk_req | input | 1 | Disk controller completion request, synchronous level |
| rd_stb | input | 1 | CPU memory read strobe, one cycle per access |
| addr | input | 16 | CPU address |
| dsk_clr | input | 1 | Disk flag clear strobe (controller status read) |
| irq_n | output | 1 | Maskable interrupt request, active low |
| stat_q | output | 8 | Status byte driven during a status read |

## Verification
The assertions assume that `rd_stb` and `dsk_clr` are one-cycle strobes sampled at clock edges. They also assume that `dsk_req` is already synchronous to `clk` and that reset is applied from time zero. The bench meets these assumptions by changing every input on the falling clock edge. It keeps `tick_in` low for several cycles between rises, so that each rise reaches the edge detector as a clean edge.

The main sweep works through every combination of the following, each from a fresh reset:
- the prior flag state;
- the access type: no strobe, a strobe to the wrong address, or a true status read;
- a coinciding tick edge;
- the disk request;
- the disk clear.

Stimulus is timed so that the synchronised tick edge and the strobes land on the same edge.

// File: rtl/isl_pkg.sv
// Shared constants for the dual-source interrupt status latch.
// Assumes the source index sets the status bit: source i is shown on bit DATA_W-1-i.
package isl_pkg;
    localparam int NSRC    = 2;
    localparam int SRC_RTC = 0;
    localparam int SRC_DSK = 1;

    // Status bit position for a source index.
    function automatic int stat_bit(input int data_w, input int src);
        return data_w - 1 - src;
    endfunction
endpackage

// File: rtl/isl_edge_sync.sv
// Brings an asynchronous level into the clk domain and gives a one-cycle rise pulse.
// Assumes the input stays high and low for more than STAGES+1 clock cycles at a time.
// After reset the history is zero, so an input that is already high gives one rise.
module isl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh;

    // Shift the input through the synchroniser and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[LAST-1:0], din};
    end

    // Rising edge: newest synchronised sample high, previous one low.
    always_comb rise = sh[LAST-1] & ~sh[LAST];
endmodule

// File: rtl/isl_pend_flag.sv
// One sticky pending flag; a set on the same edge as a clear wins.
// Assumes set and clr are synchronous to clk.
module isl_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag until cleared; a fresh set overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/isl_stat_port.sv
// Decodes the status read and places the pending flags on the upper data bits.
// Assumes a read strobe lasts one cycle; the byte is combinational and is zero otherwise.
module isl_stat_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h37E0
) (
    input  logic                    rd_stb,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [isl_pkg::NSRC-1:0] pend,
    output logic                    hit,
    output logic [DATA_W-1:0]       byte_q
);
    import isl_pkg::*;

    logic [DATA_W-1:0] image;

    // Address match qualified by the read strobe.
    always_comb hit = rd_stb && (addr == STAT_ADDR);

    // Place each source's flag on its own status bit.
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            if (b >= DATA_W - NSRC) begin : g_src
                assign image[b] = pend[DATA_W-1-b];
            end else begin : g_zero
                assign image[b] = 1'b0;
            end
        end
    endgenerate

    // Drive the image only during a status read.
    always_comb byte_q = hit ? image : '0;
endmodule

// File: rtl/irq_status_latch.sv
// Dual-source interrupt status latch: a synchronised tick and a disk request each
// set a sticky flag; either flag asserts the active-low interrupt. A status read
// returns the flags and acknowledges the tick. A separate strobe acknowledges the disk.
// Assumes dsk_req, rd_stb and dsk_clr are synchronous to clk.
module irq_status_latch #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h37E0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              dsk_req,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dsk_clr,
    output logic              irq_n,
    output logic [DATA_W-1:0] stat_q
);
    import isl_pkg::*;

    logic              tick_rise;
    logic              rd_hit;
    logic [NSRC-1:0]   set_v;
    logic [NSRC-1:0]   clr_v;
    logic [NSRC-1:0]   pend;

    isl_edge_sync #(.STAGES(SYNC_STAGES)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (tick_in),
        .rise (tick_rise)
    );

    isl_stat_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .STAT_ADDR(STAT_ADDR)
    ) u_stat (
        .rd_stb(rd_stb),
        .addr  (addr),
        .pend  (pend),
        .hit   (rd_hit),
        .byte_q(stat_q)
    );

    // Route each source's set and clear event to its flag.
    always_comb begin
        set_v          = '0;
        clr_v          = '0;
        set_v[SRC_RTC] = tick_rise;
        clr_v[SRC_RTC] = rd_hit;
        set_v[SRC_DSK] = dsk_req;
        clr_v[SRC_DSK] = dsk_clr;
    end

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_flag
            isl_pend_flag u_flag (
                .clk  (clk),
                .rst_n(rst_n),
                .set  (set_v[i]),
                .clr  (clr_v[i]),
                .q    (pend[i])
            );
        end
    endgenerate

    // Interrupt is asserted (low) while any flag is pending.
    always_comb irq_n = ~(|pend);
endmodule

// File: rtl/irq_status_latch_chk.sv
// Property checker for irq_status_latch, attached by bind below.
// Assumes reset is asserted from time zero and that the strobes are synchronous to clk.
module irq_status_latch_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h37E0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dsk_req,
    input logic              rd_stb,
    input logic [ADDR_W-1:0] addr,
    input logic              dsk_clr,
    input logic              irq_n,
    input logic [DATA_W-1:0] stat_q,
    input logic              tick_rise,
    input logic [1:0]        pend
);
    logic hit_c;
    assign hit_c = rd_stb && (addr == STAT_ADDR);

    // R1
    tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> pend[0]);

    // R2
    dsk_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_req |=> pend[1]);

    // R3
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(pend[0] || pend[1]));

    // R4
    stat_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_c |-> (stat_q == {pend[0], pend[1], {(DATA_W-2){1'b0}}}));

    // R5
    stat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_c |-> (stat_q == '0));

    // R6
    rtc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && !tick_rise) |=> !pend[0]);

    // R7
    dsk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dsk_clr && !dsk_req) |=> !pend[1]);

    // R8
    rtc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !hit_c) |=> pend[0]);

    // R8
    dsk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[1] && !dsk_clr) |=> pend[1]);
endmodule

bind irq_status_latch irq_status_latch_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dsk_req  (dsk_req),
    .rd_stb   (rd_stb),
    .addr     (addr),
    .dsk_clr  (dsk_clr),
    .irq_n    (irq_n),
    .stat_q   (stat_q),
    .tick_rise(tick_rise),
    .pend     (pend)
);

// File: tb/irq_status_latch_test.sv
module irq_status_latch_test;
    localparam logic [15:0] SA = 16'h37E0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        dsk_req = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        dsk_clr = 1'b0;
    logic        irq_n;
    logic [7:0]  stat_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_status_latch uut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .dsk_req(dsk_req),
        .rd_stb(rd_stb), .addr(addr), .dsk_clr(dsk_clr),
        .irq_n(irq_n), .stat_q(stat_q)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One rising edge, then settle at the falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_in = 1'b0; dsk_req = 1'b0; rd_stb = 1'b0; dsk_clr = 1'b0;
        addr = 16'h0000;
        step(2);
        rst_n = 1'b1;
    endtask

    // Status read at the current falling edge; returns the byte, clears the tick flag.
    task automatic read_stat(output logic [7:0] b);
        rd_stb = 1'b1; addr = SA;
        #1 b = stat_q;
        step(1);
        rd_stb = 1'b0; addr = 16'h0000;
    endtask

    task automatic make_rtc();
        tick_in = 1'b1;
        step(3);
        tick_in = 1'b0;
        step(4);
    endtask

    task automatic make_dsk();
        dsk_req = 1'b1;
        step(1);
        dsk_req = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 01 expected 00");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        @(negedge clk);
        do_reset();
        // R9 reset state: no interrupt and empty status.
        chk("R9 irq_n after reset", {7'd0, irq_n}, 8'h01);
        read_stat(b);
        chk("R9 status after reset", b, 8'h00);

        // R1 latency: flag appears after the third edge from the rise.
        tick_in = 1'b1;
        step(2);
        chk("R1 not yet set", {7'd0, irq_n}, 8'h01);
        step(1);
        chk("R1 set after sync", {7'd0, irq_n}, 8'h00);
        // R1 once per rise: clear while held high, stays clear.
        read_stat(b);
        chk("R4 tick bit7", b, 8'h80);
        step(6);
        chk("R1 held tick no re-set", {7'd0, irq_n}, 8'h01);
        tick_in = 1'b0;
        step(4);

        // R2 sticky disk flag; R6 read leaves it; R7 clear.
        make_dsk();
        step(3);
        chk("R2 dsk sticky", {7'd0, irq_n}, 8'h00);
        read_stat(b);
        chk("R4 dsk bit6", b, 8'h40);
        chk("R6 read keeps dsk", {7'd0, irq_n}, 8'h00);
        dsk_clr = 1'b1;
        step(1);
        dsk_clr = 1'b0;
        chk("R7 dsk cleared", {7'd0, irq_n}, 8'h01);

        // R5 near-miss addresses and missing strobe do not read or clear.
        make_rtc();
        make_dsk();
        for (int k = 0; k < 16; k++) begin
            rd_stb = 1'b1; addr = SA ^ (16'h1 << k);
            #1 chk("R5 wrong addr idle", stat_q, 8'h00);
            step(1);
        end
        rd_stb = 1'b0; addr = SA;
        #1 chk("R5 no strobe idle", stat_q, 8'h00);
        step(1);
        read_stat(b);
        chk("R5 flags untouched", b, 8'hC0);

        // R9 reset mid-run clears pending flags.
        make_dsk();
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        chk("R9 reset clears", {7'd0, irq_n}, 8'h01);

        // Exhaustive sweep: prior flags x access kind x tick edge x request x clear.
        for (int c = 0; c < 96; c++) begin
            logic pr, pd, tk, dq, dc, hit;
            logic [7:0] expb;
            int acc;
            pr = c[0]; pd = c[1]; tk = c[2]; dq = c[3]; dc = c[4];
            acc = c / 32;
            hit = (acc == 2);
            @(negedge clk);
            do_reset();
            step(1);
            if (pr) make_rtc();
            if (pd) make_dsk();
            step(2);
            tick_in = tk;
            step(2);
            // Synchronised edge (if any) now lands on the coming edge.
            dsk_req = dq; dsk_clr = dc;
            rd_stb = (acc != 0);
            addr = (acc == 1) ? 16'h37E4 : SA;
            expb = hit ? {pr, pd, 6'd0} : 8'h00;
            #1 chk(hit ? "R4 sweep image" : "R5 sweep idle", stat_q, expb);
            step(1);
            dsk_req = 1'b0; dsk_clr = 1'b0; rd_stb = 1'b0; addr = 16'h0000; tick_in = 1'b0;
            begin
                logic er, ed;
                er = tk | (pr & ~hit);
                ed = dq | (pd & ~dc);
                chk("R3 sweep irq", {7'd0, irq_n}, {7'd0, ~(er | ed)});
                read_stat(b);
                chk((tk && hit) || (dq && dc) ? "R8 sweep set wins" :
                    "R6 R7 sweep flags", b, {er, ed, 6'd0});
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule